// File: doc/BRIEF.md
# PWM Output Action Qualifier with Continuous Override

This block turns time-base events into two PWM output levels, `pwmA` and `pwmB`. On every time-base tick it looks at the events present: counter zero, counter at period, and a compare match while counting up. Each output's control word gives a 2-bit action for each event. The output keeps its level, goes low, goes high or toggles. Output A compares the counter against `cmpValA`, and output B compares it against `cmpValB`. Both outputs share the one period that the time base reports.

A continuous override sits above the event actions. A 4-bit override word (`forceWord`) is presented as a shadow value. The shadow is copied into the active override only at a reload point chosen by `reloadMode`: at zero, at period, at either, or on every tick. An active override holds its output low or high and masks all event actions until it is released. With immediate reload and a force-low code, the output stops at the next tick.

Top module: `pwm_action_qual`

## Requirements
- R1: While `rst_n` is low, both outputs are low and no override is active. After release, outputs stay low until a tick applies an action.
- R2: Action codes are 00 keep, 01 drive low, 10 drive high, 11 toggle. The result appears on the output one clock after the rising edge that samples `tick` high.
- R3: In each control word, bits [1:0] give the zero action and bits [3:2] give the period action. Output A takes its compare action from `ctlA[5:4]` and output B from `ctlB[9:8]`. All other control bits have no effect on that output.
- R4: A compare event exists only when `countUp` is 1 and `cntVal` equals that output's compare value. A match while counting down does nothing.
- R5: When events coincide on one tick, only the highest-priority event decides: compare, then period, then zero. This holds even when that event's action is 00.
- R6: While `tick` is low, the outputs and the active override do not change, whatever the other inputs do.
- R7: The override uses `forceWord[1:0]` for A and `forceWord[3:2]` for B. Code 01 holds the output low, 10 holds it high, and 00 and 11 mean no override. An active override masks all event actions. After release, the actions resume from the held level.
- R8: `reloadMode` picks the tick at which the shadow override becomes active. The codes are 00 zero tick, 01 period tick, 10 zero or period tick, 11 every tick. The newly loaded value already governs the output on that same tick.
- R9: With `reloadMode` at 11 and a force-low code, the output is low after the next tick, whatever the event actions are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick enable; all updates happen only on it |
| cntVal | input | CNT_W | Current time-base count |
| zeroEvt | input | 1 | Counter-at-zero strobe |
| prdEvt | input | 1 | Counter-at-period strobe |
| countUp | input | 1 | 1 while counting up |
| cmpValA | input | CNT_W | Compare value for output A |
| cmpValB | input | CNT_W | Compare value for output B |
| ctlA | input | 12 | Action control word for output A |
| ctlB | input | 12 | Action control word for output B |
| forceWord | input | 4 | Shadow continuous-override value |
| reloadMode | input | 2 | Reload point for the override |
| pwmA | output | 1 | PWM output A |
| pwmB | output | 1 | PWM output B |

## Verification
The properties assume that the event strobes, count, direction and configuration are stable around the rising edge that samples `tick`. They also assume that the strobes have meaning only on a tick. The properties do not assume that zero and period are exclusive. The bench drives every input just after a falling edge, so this stability always holds. It builds the normal counter sequence from its own up and up-down time base. It then adds a phase of arbitrary input values in which zero and period can coincide, the count can stall, and overrides and reload modes change at any time. This exercises the priority and reload rules beyond what a well-formed time base would produce.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

  localparam int CTL_W = 12;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } aqAct_t;

  // strobes from event control to the output datapath
  typedef struct packed {
    logic       tick;
    logic       zero;
    logic       prd;
    logic [1:0] cmpHit;
    logic       reload;
  } aqStrobe_t;

  function automatic logic applyAct(input logic cur, input logic [1:0] act);
    case (aqAct_t'(act))
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_TOG:  return ~cur;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/aq_event_ctrl.sv
module aq_event_ctrl
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             tick,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             zeroEvt,
  input  logic             prdEvt,
  input  logic             countUp,
  input  logic [CNT_W-1:0] cmpValA,
  input  logic [CNT_W-1:0] cmpValB,
  input  logic [1:0]       reloadMode,
  output aqStrobe_t        strb
);

  localparam int NUM_CH = 2;

  logic [CNT_W-1:0] cmpVals [NUM_CH];
  logic [NUM_CH-1:0] hits;
  logic reloadPoint;

  assign cmpVals[0] = cmpValA;
  assign cmpVals[1] = cmpValB;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_cmp
    assign hits[ch] = countUp && (cntVal == cmpVals[ch]);
  end

  always_comb begin
    case (reloadMode)
      2'b00:   reloadPoint = zeroEvt;
      2'b01:   reloadPoint = prdEvt;
      2'b10:   reloadPoint = zeroEvt | prdEvt;
      default: reloadPoint = 1'b1;
    endcase
  end

  always_comb begin
    strb.tick   = tick;
    strb.zero   = tick & zeroEvt;
    strb.prd    = tick & prdEvt;
    strb.cmpHit = tick ? hits : '0;
    strb.reload = tick & reloadPoint;
  end

endmodule

// File: rtl/aq_out_dpath.sv
module aq_out_dpath
  import pwm_aq_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  aqStrobe_t               strb,
  input  logic [NUM_CH*CTL_W-1:0] ctlWords,
  input  logic [2*NUM_CH-1:0]     forceShadow,
  output logic [NUM_CH-1:0]       pwmOut
);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int CMP_LSB = 4 + 4 * ch;

    logic [CTL_W-1:0] ctl;
    logic [1:0] forceReg, nextForce, evAct;
    logic outReg, evLevel, isForced;

    assign ctl = ctlWords[ch*CTL_W +: CTL_W];
    assign nextForce = strb.reload ? forceShadow[2*ch +: 2] : forceReg;
    assign isForced = (nextForce == 2'b01) || (nextForce == 2'b10);

    always_comb begin
      if (strb.cmpHit[ch])  evAct = ctl[CMP_LSB +: 2];
      else if (strb.prd)    evAct = ctl[3:2];
      else if (strb.zero)   evAct = ctl[1:0];
      else                  evAct = ACT_KEEP;
    end

    assign evLevel = applyAct(outReg, evAct);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        forceReg <= 2'b00;
        outReg   <= 1'b0;
      end else if (strb.tick) begin
        forceReg <= nextForce;
        outReg   <= isForced ? nextForce[1] : evLevel;
      end
    end

    assign pwmOut[ch] = outReg;
  end

endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwm_aq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cntVal,
  input  logic             zeroEvt,
  input  logic             prdEvt,
  input  logic             countUp,
  input  logic [CNT_W-1:0] cmpValA,
  input  logic [CNT_W-1:0] cmpValB,
  input  logic [11:0]      ctlA,
  input  logic [11:0]      ctlB,
  input  logic [3:0]       forceWord,
  input  logic [1:0]       reloadMode,
  output logic             pwmA,
  output logic             pwmB
);

  aqStrobe_t strb;
  logic [1:0] pwmOut;

  aq_event_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .tick(tick), .cntVal(cntVal), .zeroEvt(zeroEvt), .prdEvt(prdEvt),
    .countUp(countUp), .cmpValA(cmpValA), .cmpValB(cmpValB),
    .reloadMode(reloadMode), .strb(strb)
  );

  aq_out_dpath #(.NUM_CH(2)) i_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .ctlWords({ctlB, ctlA}), .forceShadow(forceWord), .pwmOut(pwmOut)
  );

  assign pwmA = pwmOut[0];
  assign pwmB = pwmOut[1];

endmodule

// File: rtl/pwm_action_qual_chk.sv
module pwm_action_qual_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [CNT_W-1:0] cntVal,
  input logic             countUp,
  input logic [CNT_W-1:0] cmpValA,
  input logic [11:0]      ctlA,
  input logic [3:0]       forceWord,
  input logic [1:0]       reloadMode,
  input logic             pwmA,
  input logic             pwmB
);

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> (!pwmA && !pwmB));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pwmA) && $stable(pwmB)));

  // R9
  stop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reloadMode == 2'b11 && forceWord[1:0] == 2'b01) |=> !pwmA);

  // R7
  force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reloadMode == 2'b11 && forceWord[3:2] == 2'b10) |=> pwmB);

  // R5
  cmp_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reloadMode == 2'b11 && forceWord[1:0] == 2'b00 && countUp &&
     cntVal == cmpValA && ctlA[5:4] == 2'b01) |=> !pwmA);

endmodule

bind pwm_action_qual pwm_action_qual_chk #(.CNT_W(CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .cntVal(cntVal), .countUp(countUp),
  .cmpValA(cmpValA), .ctlA(ctlA), .forceWord(forceWord),
  .reloadMode(reloadMode), .pwmA(pwmA), .pwmB(pwmB)
);

// File: tb/test_pwm_action_qual.sv
`timescale 1ns/1ps
module test_pwm_action_qual;

  localparam int CNT_W = 16;
  localparam real HALF = 2.0;

  logic clk = 1'b0;
  logic rst_n, tick, zeroEvt, prdEvt, countUp;
  logic [CNT_W-1:0] cntVal, cmpValA, cmpValB;
  logic [11:0] ctlA, ctlB;
  logic [3:0] forceWord;
  logic [1:0] reloadMode;
  logic pwmA, pwmB;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  int refOut [2];
  int refForce [2];

  always #(HALF) clk = ~clk;

  pwm_action_qual #(.CNT_W(CNT_W)) i_pwm_action_qual (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cntVal(cntVal),
    .zeroEvt(zeroEvt), .prdEvt(prdEvt), .countUp(countUp),
    .cmpValA(cmpValA), .cmpValB(cmpValB), .ctlA(ctlA), .ctlB(ctlB),
    .forceWord(forceWord), .reloadMode(reloadMode), .pwmA(pwmA), .pwmB(pwmB)
  );

  task automatic compareOuts();
    checks++;
    if (pwmA !== refOut[0][0]) begin
      errors++;
      $display("FAIL %s pwmA actual %b expected %0d", curReq, pwmA, refOut[0]);
    end
    checks++;
    if (pwmB !== refOut[1][0]) begin
      errors++;
      $display("FAIL %s pwmB actual %b expected %0d", curReq, pwmB, refOut[1]);
    end
  endtask

  // behavioural reference for one sampled edge
  task automatic modelEdge();
    int shadow, ctl, cmpv, act, code;
    bit load;
    if (!rst_n) begin
      refOut = '{0, 0}; refForce = '{0, 0};
      return;
    end
    if (!tick) return;
    case (int'(reloadMode))
      0: load = zeroEvt;
      1: load = prdEvt;
      2: load = zeroEvt || prdEvt;
      default: load = 1;
    endcase
    for (int ch = 0; ch < 2; ch++) begin
      shadow = (int'(forceWord) >> (2 * ch)) & 3;
      if (load) refForce[ch] = shadow;
      ctl  = (ch == 0) ? int'(ctlA) : int'(ctlB);
      cmpv = (ch == 0) ? int'(cmpValA) : int'(cmpValB);
      if (countUp && int'(cntVal) == cmpv) act = (ch == 0) ? (ctl >> 4) & 3 : (ctl >> 8) & 3;
      else if (prdEvt) act = (ctl >> 2) & 3;
      else if (zeroEvt) act = ctl & 3;
      else act = 0;
      code = refForce[ch];
      if (code == 1) refOut[ch] = 0;
      else if (code == 2) refOut[ch] = 1;
      else if (act == 1) refOut[ch] = 0;
      else if (act == 2) refOut[ch] = 1;
      else if (act == 3) refOut[ch] = 1 - refOut[ch];
    end
  endtask

  task automatic cyc(input bit tk, input int c, input bit z, input bit p, input bit up);
    tick = tk; cntVal = CNT_W'(c); zeroEvt = z; prdEvt = p; countUp = up;
    modelEdge();
    @(negedge clk);
    compareOuts();
  endtask

  task automatic runUp(input int prd, input int periods, input bit gaps);
    for (int n = 0; n < periods; n++)
      for (int c = 0; c <= prd; c++) begin
        cyc(1, c, c == 0, c == prd, 1);
        if (gaps) cyc(0, c, 1, 1, 1);  // R6: strobes present without tick
      end
  endtask

  task automatic runUpDown(input int prd);
    for (int c = 0; c <= prd; c++) cyc(1, c, c == 0, c == prd, 1);
    for (int c = prd - 1; c >= 1; c--) cyc(1, c, 0, 0, 0);
  endtask

  initial begin
    rst_n = 0; tick = 0; cntVal = '0; zeroEvt = 0; prdEvt = 0; countUp = 1;
    cmpValA = '0; cmpValB = '0; ctlA = '0; ctlB = '0; forceWord = '0; reloadMode = '0;
    refOut = '{0, 0}; refForce = '{0, 0};
    // R1: reset holds outputs low even with ticks and actions present
    ctlA = 12'h00A; ctlB = 12'h00A;
    for (int i = 0; i < 3; i++) cyc(1, 0, 1, 0, 1);
    rst_n = 1;
    cyc(0, 0, 0, 0, 1);

    // R2 R3: normal polarity, with unused compare fields filled
    curReq = "R3";
    cmpValA = 3; cmpValB = 6;
    ctlA = 12'h31A; ctlB = 12'h13A;
    runUp(9, 2, 0);

    // R2: inverted polarity
    curReq = "R2";
    ctlA = 12'h025; ctlB = 12'h205;
    runUp(9, 2, 0);

    // R2 R6: toggles with idle cycles between ticks
    curReq = "R6";
    ctlA = 12'h033; ctlB = 12'h30C;
    runUp(7, 2, 1);

    // R4: match while counting down is ignored
    curReq = "R4";
    cmpValA = 4; cmpValB = 2;
    ctlA = 12'h01A; ctlB = 12'h10A;
    runUpDown(8);
    runUpDown(8);

    // R5: compare coincides with zero (A) and with period (B, keep action)
    curReq = "R5";
    cmpValA = 0; cmpValB = 8;
    ctlA = 12'h012; ctlB = 12'h009;
    runUp(8, 2, 0);
    ctlA = 12'h006; ctlB = 12'h009;
    cyc(1, 5, 1, 1, 1);
    cyc(1, 5, 1, 1, 0);

    // R7 R8: force low on A, loaded at zero only
    curReq = "R8";
    cmpValA = 3; cmpValB = 5;
    ctlA = 12'h01A; ctlB = 12'h10A;
    reloadMode = 2'b00; forceWord = 4'b0001;
    runUp(9, 2, 0);
    // B forced high at period reload
    reloadMode = 2'b01; forceWord = 4'b1000;
    runUp(9, 2, 0);
    // release at zero or period, code 11 counts as none
    curReq = "R7";
    reloadMode = 2'b10; forceWord = 4'b1111;
    runUp(9, 2, 0);
    forceWord = 4'b0110;
    runUp(9, 1, 0);
    forceWord = 4'b0000;
    runUp(9, 2, 0);

    // R9: stop both outputs immediately
    curReq = "R9";
    ctlA = 12'h02A; ctlB = 12'h20A;
    runUp(9, 1, 0);
    cyc(1, 4, 0, 0, 1);
    reloadMode = 2'b11; forceWord = 4'b0101;
    cyc(0, 5, 0, 0, 1);
    cyc(1, 5, 0, 0, 1);
    runUp(9, 1, 0);

    // R5 R8: arbitrary inputs
    curReq = "R5";
    for (int i = 0; i < 600; i++) begin
      cmpValA = CNT_W'($urandom_range(0, 5));
      cmpValB = CNT_W'($urandom_range(0, 5));
      ctlA = 12'($urandom); ctlB = 12'($urandom);
      if ($urandom_range(0, 3) == 0) forceWord = 4'($urandom);
      reloadMode = 2'($urandom);
      cyc(1'($urandom), $urandom_range(0, 5), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(HALF * 2 * 100000);
    errors++;
    $display("FAIL watchdog expired, actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule